// File: doc/BRIEF.md
# ADC Queue DMA Mover

This block feeds an analog-to-digital converter's command FIFO and drains its result FIFO without software doing each move. It has two channels. Channel 0, the command channel, walks a command queue held in memory and copies one 32-bit command per request into a fixed push register. Channel 1, the result channel, copies one 16-bit result per request from a fixed pop register into a receive queue in memory. Each pulse on a channel's request line moves exactly one element.

Each channel is set up with a base byte address, a queue length in elements and an end-of-queue mode, and is then started with an enable pulse. The channel keeps a pointer and a remaining count. When the last element has been moved, the channel either stops and raises a done flag, or reloads its pointer and count from the setup and carries on, raising a one-cycle wrap pulse. Both channels share a single valid/ready memory port. A round-robin arbiter picks the channel, and each element is carried out as a read followed by a write with nothing in between.

The memory port follows a valid/ready rule. A transfer takes place on a clock edge where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the block holds `mem_valid` and keeps address, direction, size and write data unchanged. For a read, the memory presents `mem_rdata` in the handshake cycle. The memory may stall for any number of cycles.

Top module: `adcq_dma_mover`

## Requirements
- R1: An accepted request on channel 0 reads one 32-bit word at the channel pointer (`mem_size`=1, `mem_we`=0) and writes that word, with `mem_size`=1, to the fixed push address. One cycle after the write handshake, `ch_ack[0]` is high for exactly one cycle.
- R2: After an enable, the channel 0 pointer starts at the base and rises by 4 with each element. Its write address never moves off the push address.
- R3: An accepted request on channel 1 reads 16 bits (`mem_rdata[15:0]`, `mem_size`=0) from the fixed pop address and writes them, with `mem_size`=0 and the value in `mem_wdata[15:0]`, at the channel pointer. The pointer starts at the base and rises by 2 with each element. `ch_ack[1]` pulses as in R1.
- R4: In stop mode (`cfg_cyclic`=0), finishing element number `len` clears `ch_active` and sets `ch_done`. These change in the same cycle as the ack. `ch_done` stays set until the next accepted enable.
- R5: In cyclic mode (`cfg_cyclic`=1), finishing the last element raises `ch_wrap` for one cycle, keeps the channel active, and reloads pointer and count so that the next element uses the base address again.
- R6: A request is dropped and sets the sticky `ch_err` bit of its channel in two cases: the channel is inactive, or a request of that channel is still pending. A dropped request causes no memory transfer and no ack. An accepted enable clears `ch_err`.
- R7: A setup write (`cfg_wr`, target chosen by `cfg_ch`) to an active channel is ignored. An enable pulse to an active channel is ignored, and so is an enable while the stored length is 0.
- R8: When both channels are pending at an arbitration point, the channel not served most recently wins. The first grant after reset goes to channel 0.
- R9: Every element is one read handshake followed directly by one write handshake of the same size. No handshake of the other channel falls between them.
- R10: While `mem_valid` is high and `mem_ready` is low, the next cycle keeps `mem_valid` high with `mem_addr`, `mem_we`, `mem_size` and `mem_wdata` unchanged.
- R11: After reset, both channels are inactive and every status output is 0. `mem_valid` is 0 as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Setup write strobe |
| cfg_ch | input | 1 | Setup target: 0 command, 1 result |
| cfg_base | input | AW | Queue base byte address |
| cfg_len | input | LW | Queue length in elements |
| cfg_cyclic | input | 1 | End mode: 0 stop, 1 cyclic |
| ch_enable | input | 2 | Per-channel start pulse |
| ch_req | input | 2 | Per-channel one-element request pulse |
| ch_ack | output | 2 | One-cycle element-complete pulse |
| ch_active | output | 2 | Channel enabled |
| ch_done | output | 2 | Sticky stop-mode completion flag |
| ch_wrap | output | 2 | One-cycle cyclic wrap pulse |
| ch_err | output | 2 | Sticky dropped-request flag |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 1 | 1 for 32-bit, 0 for 16-bit |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the read handshake cycle |

## Verification
The assertions rely on two things about the environment. The memory only acknowledges while `mem_valid` is high, and every word-size write goes to the push address while every half-size read comes from the pop address. The checks on round-robin order and on atomicity also rely on request, enable and setup pulses lasting one cycle. The bench stalls `mem_ready` at random but only acts on a handshake, and it drives each pulse for a single cycle at the falling edge. Apart from the deliberate drop cases, the bench waits for a channel's ack before it requests that channel again.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  localparam int NCH    = 2;
  localparam int CH_CMD = 0;
  localparam int CH_RES = 1;

  typedef enum logic {
    END_STOP   = 1'b0,
    END_CYCLIC = 1'b1
  } end_mode_e;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/adcq_chan.sv
module adcq_chan #(
  parameter int              AW           = 16,
  parameter int              LW           = 16,
  parameter int              STEP         = 4,
  parameter bit              QUEUE_IS_SRC = 1'b1,
  parameter logic [AW-1:0]   FIFO_ADDR    = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [AW-1:0]       cfg_base,
  input  logic [LW-1:0]       cfg_len,
  input  adcq_pkg::end_mode_e cfg_mode,
  input  logic                en_set,
  input  logic                req,
  input  logic                fin,
  output logic                pend,
  output logic                active,
  output logic                ack,
  output logic                done,
  output logic                wrap,
  output logic                err,
  output logic [AW-1:0]       src_addr,
  output logic [AW-1:0]       dst_addr
);
  import adcq_pkg::*;

  logic [AW-1:0] base_q, ptr_q;
  logic [LW-1:0] len_q, cnt_q;
  end_mode_e     mode_q;
  logic          last_elem;

  assign last_elem = (cnt_q == LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      mode_q <= END_STOP;
      ptr_q  <= '0;
      cnt_q  <= '0;
      active <= 1'b0;
      pend   <= 1'b0;
      ack    <= 1'b0;
      done   <= 1'b0;
      wrap   <= 1'b0;
      err    <= 1'b0;
    end else begin
      ack  <= 1'b0;
      wrap <= 1'b0;
      if (cfg_wr && !active) begin
        base_q <= cfg_base;
        len_q  <= cfg_len;
        mode_q <= cfg_mode;
      end
      if (en_set && !active && (len_q != '0)) begin
        active <= 1'b1;
        ptr_q  <= base_q;
        cnt_q  <= len_q;
        done   <= 1'b0;
        err    <= 1'b0;
      end
      if (req) begin
        if (active && !pend) pend <= 1'b1;
        else                 err  <= 1'b1;
      end
      if (fin) begin
        pend <= 1'b0;
        ack  <= 1'b1;
        if (last_elem) begin
          if (mode_q == END_CYCLIC) begin
            ptr_q <= base_q;
            cnt_q <= len_q;
            wrap  <= 1'b1;
          end else begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end else begin
          ptr_q <= ptr_q + AW'(STEP);
          cnt_q <= cnt_q - LW'(1);
        end
      end
    end
  end

  generate
    if (QUEUE_IS_SRC) begin : g_queue_src
      assign src_addr = ptr_q;
      assign dst_addr = FIFO_ADDR;
    end else begin : g_queue_dst
      assign src_addr = FIFO_ADDR;
      assign dst_addr = ptr_q;
    end
  endgenerate
endmodule

// File: rtl/adcq_arb.sv
module adcq_arb #(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend_vec,
  input  logic           take,
  output logic           gnt_any,
  output logic [CW-1:0]  gnt_id
);
  logic [CW-1:0] last_q;

  always_comb begin
    gnt_any = 1'b0;
    gnt_id  = last_q;
    for (int k = 1; k <= NCH; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NCH;
      if (!gnt_any && pend_vec[idx]) begin
        gnt_any = 1'b1;
        gnt_id  = CW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= CW'(NCH - 1);
    else if (take) last_q <= gnt_id;
  end
endmodule

// File: rtl/adcq_xfer.sv
module adcq_xfer #(
  parameter int             AW        = 16,
  parameter int             NCH       = 2,
  parameter logic [NCH-1:0] WORD_MASK = 2'b01,
  localparam int            CW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    gnt_any,
  input  logic [CW-1:0]           gnt_id,
  input  logic [NCH-1:0][AW-1:0]  src_addrs,
  input  logic [NCH-1:0][AW-1:0]  dst_addrs,
  output logic                    take,
  output logic                    fin,
  output logic [CW-1:0]           fin_id,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_we,
  output logic                    mem_size,
  output logic [AW-1:0]           mem_addr,
  output logic [31:0]             mem_wdata,
  input  logic [31:0]             mem_rdata
);
  import adcq_pkg::*;

  xfer_state_e   st_q;
  logic [CW-1:0] cur_q;
  logic [31:0]   data_q;

  assign take      = (st_q == XS_IDLE) && gnt_any;
  assign mem_valid = (st_q != XS_IDLE);
  assign mem_we    = (st_q == XS_WRITE);
  assign mem_size  = WORD_MASK[cur_q];
  assign mem_addr  = (st_q == XS_WRITE) ? dst_addrs[cur_q] : src_addrs[cur_q];
  assign mem_wdata = data_q;
  assign fin       = (st_q == XS_WRITE) && mem_ready;
  assign fin_id    = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      cur_q  <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        XS_IDLE: if (gnt_any) begin
          cur_q <= gnt_id;
          st_q  <= XS_READ;
        end
        XS_READ: if (mem_ready) begin
          data_q <= WORD_MASK[cur_q] ? mem_rdata : {16'h0000, mem_rdata[15:0]};
          st_q   <= XS_WRITE;
        end
        XS_WRITE: if (mem_ready) st_q <= XS_IDLE;
        default: st_q <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcq_dma_mover.sv
module adcq_dma_mover #(
  parameter int            AW        = 16,
  parameter int            LW        = 16,
  parameter logic [AW-1:0] PUSH_ADDR = AW'('hFF00),
  parameter logic [AW-1:0] POP_ADDR  = AW'('hFF04),
  localparam int           NCH       = adcq_pkg::NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic           cfg_ch,
  input  logic [AW-1:0]  cfg_base,
  input  logic [LW-1:0]  cfg_len,
  input  logic           cfg_cyclic,
  input  logic [NCH-1:0] ch_enable,
  input  logic [NCH-1:0] ch_req,
  output logic [NCH-1:0] ch_ack,
  output logic [NCH-1:0] ch_active,
  output logic [NCH-1:0] ch_done,
  output logic [NCH-1:0] ch_wrap,
  output logic [NCH-1:0] ch_err,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic           mem_size,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata
);
  import adcq_pkg::*;

  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [NCH-1:0] WORD_MASK = NCH'(1) << CH_CMD;

  logic [NCH-1:0]          pend_vec;
  logic [NCH-1:0][AW-1:0]  src_addrs, dst_addrs;
  logic                    gnt_any, take, fin;
  logic [CW-1:0]           gnt_id, fin_id;
  end_mode_e               cfg_mode;

  assign cfg_mode = end_mode_e'(cfg_cyclic);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel_cfg, fin_c;
      assign sel_cfg = cfg_wr && (cfg_ch == CW'(c));
      assign fin_c   = fin && (fin_id == CW'(c));
      if (c == CH_CMD) begin : g_cmd
        adcq_chan #(.AW(AW), .LW(LW), .STEP(4), .QUEUE_IS_SRC(1'b1),
                    .FIFO_ADDR(PUSH_ADDR)) u_chan (
          .clk(clk), .rst_n(rst_n), .cfg_wr(sel_cfg), .cfg_base(cfg_base),
          .cfg_len(cfg_len), .cfg_mode(cfg_mode), .en_set(ch_enable[c]),
          .req(ch_req[c]), .fin(fin_c), .pend(pend_vec[c]),
          .active(ch_active[c]), .ack(ch_ack[c]), .done(ch_done[c]),
          .wrap(ch_wrap[c]), .err(ch_err[c]),
          .src_addr(src_addrs[c]), .dst_addr(dst_addrs[c]));
      end else begin : g_res
        adcq_chan #(.AW(AW), .LW(LW), .STEP(2), .QUEUE_IS_SRC(1'b0),
                    .FIFO_ADDR(POP_ADDR)) u_chan (
          .clk(clk), .rst_n(rst_n), .cfg_wr(sel_cfg), .cfg_base(cfg_base),
          .cfg_len(cfg_len), .cfg_mode(cfg_mode), .en_set(ch_enable[c]),
          .req(ch_req[c]), .fin(fin_c), .pend(pend_vec[c]),
          .active(ch_active[c]), .ack(ch_ack[c]), .done(ch_done[c]),
          .wrap(ch_wrap[c]), .err(ch_err[c]),
          .src_addr(src_addrs[c]), .dst_addr(dst_addrs[c]));
      end
    end
  endgenerate

  adcq_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend_vec(pend_vec), .take(take),
    .gnt_any(gnt_any), .gnt_id(gnt_id));

  adcq_xfer #(.AW(AW), .NCH(NCH), .WORD_MASK(WORD_MASK)) u_xfer (
    .clk(clk), .rst_n(rst_n), .gnt_any(gnt_any), .gnt_id(gnt_id),
    .src_addrs(src_addrs), .dst_addrs(dst_addrs), .take(take), .fin(fin),
    .fin_id(fin_id), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));
endmodule

// File: rtl/adcq_checker.sv
module adcq_checker #(
  parameter int            AW        = 16,
  parameter int            NCH       = 2,
  parameter logic [AW-1:0] PUSH_ADDR = '0,
  parameter logic [AW-1:0] POP_ADDR  = '0
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_we,
  input logic           mem_size,
  input logic [AW-1:0]  mem_addr,
  input logic [31:0]    mem_wdata,
  input logic [NCH-1:0] ch_ack,
  input logic [NCH-1:0] ch_active,
  input logic [NCH-1:0] ch_done,
  input logic [NCH-1:0] ch_wrap
);
  logic rd_open, rd_word;
  logic hs;
  assign hs = mem_valid && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_open <= 1'b0;
      rd_word <= 1'b0;
    end else if (hs) begin
      rd_open <= !mem_we;
      if (!mem_we) rd_word <= mem_size;
    end
  end

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_size) && $stable(mem_wdata));

  p_write_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hs && mem_we |-> rd_open && (mem_size == rd_word));

  p_read_not_nested_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !mem_we |-> !rd_open);

  p_word_write_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && mem_size |-> mem_addr == PUSH_ADDR);

  p_half_read_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we && !mem_size |-> mem_addr == POP_ADDR);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ch_ack[c] |=> !ch_ack[c]);
      p_done_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_done[c]) |-> !ch_active[c] && ch_ack[c]);
      p_wrap_keeps_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ch_wrap[c] |-> ch_active[c] && ch_ack[c]);
    end
  endgenerate
endmodule

bind adcq_dma_mover adcq_checker #(
  .AW(AW), .NCH(NCH), .PUSH_ADDR(PUSH_ADDR), .POP_ADDR(POP_ADDR)
) u_adcq_checker (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .ch_ack(ch_ack), .ch_active(ch_active),
  .ch_done(ch_done), .ch_wrap(ch_wrap));

// File: tb/tb_adcq_dma_mover.sv
module tb_adcq_dma_mover;
  localparam int            CLK_PERIOD = 10;
  localparam int            AW   = 12;
  localparam int            LW   = 16;
  localparam logic [AW-1:0] PUSH = 12'hF00;
  localparam logic [AW-1:0] POP  = 12'hF04;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cfg_wr = 0, cfg_ch = 0, cfg_cyclic = 0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_len = '0;
  logic [1:0]    ch_enable = '0, ch_req = '0;
  logic [1:0]    ch_ack, ch_active, ch_done, ch_wrap, ch_err;
  logic          mem_valid, mem_ready = 1'b0, mem_we, mem_size;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;

  adcq_dma_mover #(.AW(AW), .LW(LW), .PUSH_ADDR(PUSH), .POP_ADDR(POP)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_cyclic(cfg_cyclic),
    .ch_enable(ch_enable), .ch_req(ch_req), .ch_ack(ch_ack),
    .ch_active(ch_active), .ch_done(ch_done), .ch_wrap(ch_wrap),
    .ch_err(ch_err), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int idx);
    return 32'hC0DE0000 ^ (idx * 32'h9E37);
  endfunction

  // ---------------- memory model and monitor ----------------
  logic [31:0] mem [0:1023];
  logic [15:0] pop_val = 16'h1234;
  logic [15:0] last_pop;
  logic [31:0] last_push;
  int push_cnt = 0, pop_cnt = 0, wn = 0, seq_viol = 0, hold_viol = 0;
  int ack_cnt [2] = '{0, 0};
  int wrap_cnt [2] = '{0, 0};
  logic wseq [0:511];
  bit rd_open = 0, prev_stall = 0;
  logic [AW-1:0] p_addr; logic p_we, p_size; logic [31:0] p_wdata;

  initial for (int i = 0; i < 1024; i++) mem[i] = pat(i);

  always_comb begin
    if (mem_addr == POP)  mem_rdata = {16'h0000, pop_val};
    else if (mem_size)    mem_rdata = mem[mem_addr[11:2]];
    else                  mem_rdata = {16'h0000, mem_addr[1] ? mem[mem_addr[11:2]][31:16]
                                                             : mem[mem_addr[11:2]][15:0]};
  end

  always @(negedge clk) mem_ready = ($urandom % 10) < 7;

  always @(posedge clk) if (rst_n) begin
    if (prev_stall && (!mem_valid || mem_addr != p_addr || mem_we != p_we ||
                       mem_size != p_size || mem_wdata != p_wdata)) hold_viol++;
    prev_stall = mem_valid && !mem_ready;
    p_addr = mem_addr; p_we = mem_we; p_size = mem_size; p_wdata = mem_wdata;
    if (mem_valid && mem_ready) begin
      if (!mem_we) begin
        if (rd_open) seq_viol++;
        rd_open = 1;
        if (mem_addr == POP) begin
          last_pop = pop_val;
          pop_cnt++;
          pop_val <= 16'($urandom);
        end
      end else begin
        if (!rd_open) seq_viol++;
        rd_open = 0;
        if (mem_addr == PUSH) begin
          last_push = mem_wdata;
          push_cnt++;
          wseq[wn % 512] = 1'b0;
        end else begin
          if (mem_size) mem[mem_addr[11:2]] <= mem_wdata;
          else if (mem_addr[1]) mem[mem_addr[11:2]][31:16] <= mem_wdata[15:0];
          else mem[mem_addr[11:2]][15:0] <= mem_wdata[15:0];
          wseq[wn % 512] = 1'b1;
        end
        wn++;
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (ch_ack[c])  ack_cnt[c]++;
      if (ch_wrap[c]) wrap_cnt[c]++;
    end
  end

  // ---------------- reference model ----------------
  bit          m_act [2], m_done [2], m_cyc [2];
  logic [AW-1:0] m_base [2], m_ptr [2];
  int          m_len [2], m_cnt [2], m_wrap [2];

  task automatic cfg(input int c, input logic [AW-1:0] b, input int len, input bit cyc);
    @(negedge clk);
    cfg_wr = 1; cfg_ch = c[0]; cfg_base = b; cfg_len = LW'(len); cfg_cyclic = cyc;
    @(negedge clk);
    cfg_wr = 0;
    if (!m_act[c]) begin m_base[c] = b; m_len[c] = len; m_cyc[c] = cyc; end
  endtask

  task automatic enable(input int c);
    @(negedge clk);
    ch_enable[c] = 1;
    @(negedge clk);
    ch_enable[c] = 0;
    if (!m_act[c] && m_len[c] != 0) begin
      m_act[c] = 1; m_ptr[c] = m_base[c]; m_cnt[c] = m_len[c]; m_done[c] = 0;
    end
    chk(ch_active[c] == m_act[c], "R7 enable result", 32'(ch_active[c]), 32'(m_act[c]));
  endtask

  task automatic wait_ack(input int c, input int base, output bit ok);
    ok = 0;
    for (int i = 0; i < 400 && !ok; i++) begin
      @(negedge clk);
      if (ack_cnt[c] != base) ok = 1;
    end
  endtask

  task automatic finish_elem(input int c, input bit ok, input int pc);
    logic [15:0] half;
    chk(ok, "R1 ack after request", 32'(ok), 1);
    if (c == 0) begin
      chk(push_cnt == pc + 1, "R1 one push per request", push_cnt, pc + 1);
      chk(last_push == pat(int'(m_ptr[0] >> 2)), "R2 pushed command word", last_push,
          pat(int'(m_ptr[0] >> 2)));
    end else begin
      half = m_ptr[1][1] ? mem[m_ptr[1][11:2]][31:16] : mem[m_ptr[1][11:2]][15:0];
      chk(half == last_pop, "R3 result stored at queue pointer", 32'(half), 32'(last_pop));
    end
    if (m_cnt[c] == 1) begin
      if (m_cyc[c]) begin m_ptr[c] = m_base[c]; m_cnt[c] = m_len[c]; m_wrap[c]++; end
      else begin m_act[c] = 0; m_done[c] = 1; end
    end else begin
      m_ptr[c] = m_ptr[c] + AW'((c == 0) ? 4 : 2);
      m_cnt[c]--;
    end
    chk(ch_active[c] == m_act[c], "R4 active after element", 32'(ch_active[c]), 32'(m_act[c]));
    chk(ch_done[c] == m_done[c], "R4 done after element", 32'(ch_done[c]), 32'(m_done[c]));
    chk(wrap_cnt[c] == m_wrap[c], "R5 wrap pulses", wrap_cnt[c], m_wrap[c]);
  endtask

  task automatic do_req(input int c);
    int ab, pc, pp; bit ok;
    ab = ack_cnt[c]; pc = push_cnt; pp = pop_cnt;
    @(negedge clk); ch_req[c] = 1;
    @(negedge clk); ch_req[c] = 0;
    if (m_act[c]) begin
      wait_ack(c, ab, ok);
      finish_elem(c, ok, pc);
    end else begin
      repeat (10) @(negedge clk);
      chk(ack_cnt[c] == ab, "R6 no ack when inactive", ack_cnt[c], ab);
      chk(push_cnt == pc && pop_cnt == pp, "R6 no transfer when inactive", push_cnt + pop_cnt, pc + pp);
      chk(ch_err[c] == 1'b1, "R6 error flag set", 32'(ch_err[c]), 1);
    end
  endtask

  task automatic do_both();
    int a0, a1, pc, idx0; bit ok0, ok1, prev;
    a0 = ack_cnt[0]; a1 = ack_cnt[1]; pc = push_cnt; idx0 = wn;
    prev = (idx0 > 0) ? wseq[(idx0 - 1) % 512] : 1'b1;
    @(negedge clk); ch_req = 2'b11;
    @(negedge clk); ch_req = 2'b00;
    wait_ack(0, a0, ok0);
    wait_ack(1, a1, ok1);
    chk(wseq[idx0 % 512] != prev, "R8 round-robin first grant", 32'(wseq[idx0 % 512]), 32'(!prev));
    finish_elem(0, ok0, pc);
    finish_elem(1, ok1, pc);
  endtask

  // ---------------- watchdog ----------------
  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int ab;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 2; c++) begin
      m_act[c] = 0; m_done[c] = 0; m_cyc[c] = 0; m_len[c] = 0; m_wrap[c] = 0;
      m_base[c] = '0; m_ptr[c] = '0; m_cnt[c] = 0;
    end
    repeat (3) @(negedge clk);
    chk({ch_ack, ch_active, ch_done, ch_wrap, ch_err} == '0, "R11 status in reset",
        32'({ch_ack, ch_active, ch_done, ch_wrap, ch_err}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_valid == 1'b0 && ch_active == 2'b00, "R11 idle after reset", 32'({mem_valid, ch_active}), 0);

    // zero length enable ignored
    cfg(0, 12'h100, 0, 0);
    enable(0);
    chk(ch_active[0] == 1'b0, "R7 zero length enable ignored", 32'(ch_active[0]), 0);

    // command channel, stop mode
    cfg(0, 12'h100, 3, 0);
    enable(0);
    for (int i = 0; i < 3; i++) do_req(0);
    chk(ch_done[0] == 1'b1, "R4 done after last command", 32'(ch_done[0]), 1);
    do_req(0);

    // result channel, cyclic, setup write while active ignored
    cfg(1, 12'h800, 2, 1);
    enable(1);
    cfg(1, 12'h900, 5, 0);
    for (int i = 0; i < 5; i++) do_req(1);
    chk(m_ptr[1] == 12'h802 && wrap_cnt[1] == 2, "R5 cyclic wrap count", wrap_cnt[1], 2);
    enable(1);

    // command cyclic, simultaneous requests
    cfg(0, 12'h200, 2, 1);
    enable(0);
    chk(ch_err[0] == 1'b0 && ch_done[0] == 1'b0, "R6 enable clears err and done",
        32'({ch_err[0], ch_done[0]}), 0);
    for (int i = 0; i < 4; i++) do_both();

    // double request while pending
    ab = ack_cnt[0];
    @(negedge clk); ch_req[0] = 1;
    @(negedge clk); ch_req[0] = 1;
    @(negedge clk); ch_req[0] = 0;
    begin bit ok; wait_ack(0, ab, ok); finish_elem(0, ok, push_cnt - 1); end
    repeat (12) @(negedge clk);
    chk(ack_cnt[0] == ab + 1, "R6 pending request drops second", ack_cnt[0], ab + 1);
    chk(ch_err[0] == 1'b1, "R6 overrun sets error", 32'(ch_err[0]), 1);

    // constrained random phase
    for (int it = 0; it < 80; it++) begin
      int act;
      act = $urandom % 5;
      case (act)
        0: do_req(0);
        1: do_req(1);
        2: if (m_act[0] && m_act[1]) do_both();
        3: begin
          int c;
          c = $urandom % 2;
          if (!m_act[c]) begin
            cfg(c, (c == 0) ? 12'h300 : 12'hA00, 1 + ($urandom % 4), 1'($urandom % 2));
            enable(c);
          end
        end
        default: repeat (1 + ($urandom % 5)) @(negedge clk);
      endcase
    end

    repeat (5) @(negedge clk);
    chk(seq_viol == 0, "R9 read then write per element", seq_viol, 0);
    chk(hold_viol == 0, "R10 request held while stalled", hold_viol, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule